// File: doc/BRIEF.md
# Single-to-Dual Pixel Pair Splitter

This block accepts a video stream carrying one 24-bit RGB pixel on every clock, together with a data-enable and horizontal and vertical sync. It regroups that stream into pixel pairs. The first pixel of each pair goes on an odd bus and the second on an even bus. Each pair leaves on a two-pixel-wide registered output, marked by a strobe that pulses once every two input clocks. A reduced view of both buses is also driven, keeping the top six bits of each color for narrow-color panels.

Pairing is tied to the line structure. Each low-to-high change of the data-enable input restarts the pairing, so the first active pixel of every line lands on the odd bus. If a line ends on an odd pixel, that pixel is still emitted, with a zero even slot and a flag set. During blanking the block keeps emitting pairs at the same half rate, with zero colors, data-enable low and the sync levels passing through. The block expects every blanking interval to last an even number of clocks. A sticky flag records any blanking interval that breaks this rule.

Video timing cannot stall, so there is no ready input and no back-pressure. A downstream consumer must take each pair in the cycle its strobe is high. Between strobes the output holds its last value.

Top module: `pxs_pair_splitter`

## Requirements
- R1: While synchronous reset is high and in the first cycle after it, out_valid, blank_err, out_odd_only, out_de and all color outputs are zero.
- R2: A pixel is packed as red in bits 23:16, green in bits 15:8 and blue in bits 7:0, with bit 0 of each color as its LSB. The first slot of a pair appears on out_odd and the second on out_even.
- R3: Slots alternate first, second, first, and so on. out_valid is high for exactly one clock, in the cycle after the clock edge that samples a second slot. It is never high on two consecutive cycles.
- R4: The clock edge that samples in_de high after it was low always starts a first slot, even if that slot would otherwise have been a second slot. A pending half pair from blanking is then discarded.
- R5: If in_de is low in a second slot whose first slot had in_de high, the pair is emitted with out_even zero, out_de high and out_odd_only high. In every other pair out_odd_only is low.
- R6: out_hs and out_vs carry the in_hs and in_vs values sampled in the first slot of the pair.
- R7: A pair whose first slot had in_de low is emitted with out_de low and both color buses zero.
- R8: blank_err becomes high once a blanking interval ends after an odd number of in_de-low clocks, counted from the falling edge of in_de. It stays high until reset.
- R9: out_odd18 and out_even18 hold {red[7:2], green[7:2], blue[7:2]} of the matching 24-bit bus, with red in the top six bits.
- R10: While out_valid is low, every data output keeps its value from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| in_de | input | 1 | Input data enable (high = active pixel) |
| in_hs | input | 1 | Input horizontal sync |
| in_vs | input | 1 | Input vertical sync |
| in_pix | input | 24 | Input pixel {R,G,B} |
| out_valid | output | 1 | One-clock strobe marking a new pair |
| out_de | output | 1 | Data enable of the pair |
| out_hs | output | 1 | Horizontal sync from the first slot |
| out_vs | output | 1 | Vertical sync from the first slot |
| out_odd | output | 24 | First pixel of the pair |
| out_even | output | 24 | Second pixel of the pair |
| out_odd18 | output | 18 | Upper six bits per color of out_odd |
| out_even18 | output | 18 | Upper six bits per color of out_even |
| out_odd_only | output | 1 | Pair holds a lone final pixel |
| blank_err | output | 1 | Sticky flag for an odd-length blanking interval |

## Verification
Lines with even active lengths and even blanking check the plain pairing: an odd/even swap or a shifted strobe shows up at once. Lines with odd active lengths exercise the lone-pixel pair and tell it apart from an ordinary blanking pair. Odd-length blanking intervals show whether the phase restarts on the data-enable edge and whether the sticky flag is set and cleared. A long run of random line lengths and sync patterns then checks that the sync levels follow the first slot and that the held outputs stay unchanged between strobes.

// File: rtl/pxs_pkg.sv
`timescale 1ns/1ps
package pxs_pkg;
  localparam int CHANNELS     = 3;
  localparam int DEF_COLOR_W  = 8;
  localparam int DEF_NARROW_W = 6;

  typedef struct packed {
    logic de;
    logic hs;
    logic vs;
  } pxs_ctl_t;
endpackage

// File: rtl/pxs_slot_tracker.sv
`timescale 1ns/1ps
module pxs_slot_tracker (
  input  logic clk,
  input  logic rst,
  input  logic in_de,
  output logic is_first,
  output logic de_rise,
  output logic de_fall
);
  logic de_q;
  logic in_second;

  // A data-enable rising edge always opens a fresh pair.
  always_comb begin
    de_rise  = in_de & ~de_q;
    de_fall  = ~in_de & de_q;
    is_first = de_rise | ~in_second;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      de_q      <= 1'b0;
      in_second <= 1'b0;
    end else begin
      de_q      <= in_de;
      in_second <= is_first;
    end
  end
endmodule

// File: rtl/pxs_blank_mon.sv
`timescale 1ns/1ps
module pxs_blank_mon (
  input  logic clk,
  input  logic rst,
  input  logic in_de,
  input  logic de_rise,
  input  logic de_fall,
  output logic blank_err
);
  logic parity;
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      parity    <= 1'b0;
      armed     <= 1'b0;
      blank_err <= 1'b0;
    end else begin
      if (de_rise) begin
        if (armed && parity) blank_err <= 1'b1;
        parity <= 1'b0;
      end else if (!in_de) begin
        parity <= ~parity;
      end
      if (de_fall) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/pxs_pair_builder.sv
`timescale 1ns/1ps
module pxs_pair_builder
  import pxs_pkg::*;
#(
  parameter int COLOR_W  = DEF_COLOR_W,
  parameter int NARROW_W = DEF_NARROW_W,
  localparam int PIX_W   = CHANNELS * COLOR_W,
  localparam int NPIX_W  = CHANNELS * NARROW_W,
  localparam int DROP    = COLOR_W - NARROW_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              is_first,
  input  logic              in_de,
  input  logic              in_hs,
  input  logic              in_vs,
  input  logic [PIX_W-1:0]  in_pix,
  output logic              out_valid,
  output logic              out_de,
  output logic              out_hs,
  output logic              out_vs,
  output logic [PIX_W-1:0]  out_odd,
  output logic [PIX_W-1:0]  out_even,
  output logic [NPIX_W-1:0] out_odd_n,
  output logic [NPIX_W-1:0] out_even_n,
  output logic              out_odd_only
);
  pxs_ctl_t         held_ctl;
  logic [PIX_W-1:0] held_pix;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_ctl     <= '0;
      held_pix     <= '0;
      out_valid    <= 1'b0;
      out_de       <= 1'b0;
      out_hs       <= 1'b0;
      out_vs       <= 1'b0;
      out_odd      <= '0;
      out_even     <= '0;
      out_odd_only <= 1'b0;
    end else if (is_first) begin
      held_ctl  <= '{de: in_de, hs: in_hs, vs: in_vs};
      held_pix  <= in_de ? in_pix : '0;
      out_valid <= 1'b0;
    end else begin
      out_valid    <= 1'b1;
      out_de       <= held_ctl.de;
      out_hs       <= held_ctl.hs;
      out_vs       <= held_ctl.vs;
      out_odd      <= held_ctl.de ? held_pix : '0;
      out_even     <= (held_ctl.de && in_de) ? in_pix : '0;
      out_odd_only <= held_ctl.de && !in_de;
    end
  end

  for (genvar c = 0; c < CHANNELS; c++) begin : g_narrow
    assign out_odd_n[c*NARROW_W +: NARROW_W]  = out_odd[c*COLOR_W + DROP +: NARROW_W];
    assign out_even_n[c*NARROW_W +: NARROW_W] = out_even[c*COLOR_W + DROP +: NARROW_W];
  end
endmodule

// File: rtl/pxs_pair_splitter.sv
`timescale 1ns/1ps
module pxs_pair_splitter
  import pxs_pkg::*;
#(
  parameter int COLOR_W  = DEF_COLOR_W,
  parameter int NARROW_W = DEF_NARROW_W,
  localparam int PIX_W   = CHANNELS * COLOR_W,
  localparam int NPIX_W  = CHANNELS * NARROW_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_de,
  input  logic              in_hs,
  input  logic              in_vs,
  input  logic [PIX_W-1:0]  in_pix,
  output logic              out_valid,
  output logic              out_de,
  output logic              out_hs,
  output logic              out_vs,
  output logic [PIX_W-1:0]  out_odd,
  output logic [PIX_W-1:0]  out_even,
  output logic [NPIX_W-1:0] out_odd18,
  output logic [NPIX_W-1:0] out_even18,
  output logic              out_odd_only,
  output logic              blank_err
);
  logic is_first;
  logic de_rise;
  logic de_fall;

  pxs_slot_tracker i_slot (
    .clk      (clk),
    .rst      (rst),
    .in_de    (in_de),
    .is_first (is_first),
    .de_rise  (de_rise),
    .de_fall  (de_fall)
  );

  pxs_blank_mon i_blank (
    .clk       (clk),
    .rst       (rst),
    .in_de     (in_de),
    .de_rise   (de_rise),
    .de_fall   (de_fall),
    .blank_err (blank_err)
  );

  pxs_pair_builder #(
    .COLOR_W  (COLOR_W),
    .NARROW_W (NARROW_W)
  ) i_pair (
    .clk          (clk),
    .rst          (rst),
    .is_first     (is_first),
    .in_de        (in_de),
    .in_hs        (in_hs),
    .in_vs        (in_vs),
    .in_pix       (in_pix),
    .out_valid    (out_valid),
    .out_de       (out_de),
    .out_hs       (out_hs),
    .out_vs       (out_vs),
    .out_odd      (out_odd),
    .out_even     (out_even),
    .out_odd_n    (out_odd18),
    .out_even_n   (out_even18),
    .out_odd_only (out_odd_only)
  );
endmodule

// File: rtl/pxs_pair_splitter_chk.sv
`timescale 1ns/1ps
module pxs_pair_splitter_chk #(
  parameter int PIX_W  = 24,
  parameter int NPIX_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              in_de,
  input logic              in_hs,
  input logic              in_vs,
  input logic [PIX_W-1:0]  in_pix,
  input logic              out_valid,
  input logic              out_de,
  input logic              out_hs,
  input logic              out_vs,
  input logic [PIX_W-1:0]  out_odd,
  input logic [PIX_W-1:0]  out_even,
  input logic [NPIX_W-1:0] out_odd18,
  input logic [NPIX_W-1:0] out_even18,
  input logic              out_odd_only,
  input logic              blank_err
);
  logic live;
  logic de_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      live    <= 1'b0;
      de_prev <= 1'b0;
    end else begin
      live    <= 1'b1;
      de_prev <= in_de;
    end
  end

  p_single_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  p_rise_opens_pair_r4: assert property (@(posedge clk) disable iff (rst)
    (in_de && !de_prev) |=> !out_valid);

  p_lone_pixel_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_odd_only) |-> (out_de && out_even == '0));

  p_blank_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_de) |-> (out_odd == '0 && out_even == '0 && !out_odd_only));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    blank_err |=> blank_err);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst || !live)
    !out_valid |-> ($stable(out_odd) && $stable(out_even) && $stable(out_de)
                    && $stable(out_hs) && $stable(out_vs) && $stable(out_odd_only)
                    && $stable(out_odd18) && $stable(out_even18)));

  // Inputs listed so that every connected port is referenced.
  logic unused_ok;
  assign unused_ok = ^{in_hs, in_vs, in_pix};
endmodule

bind pxs_pair_splitter pxs_pair_splitter_chk i_chk (.*);

// File: tb/test_pxs_pair_splitter.sv
`timescale 1ns/1ps
module test_pxs_pair_splitter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_de = 1'b0, in_hs = 1'b0, in_vs = 1'b0;
  logic [23:0] in_pix = '0;
  logic        out_valid, out_de, out_hs, out_vs, out_odd_only, blank_err;
  logic [23:0] out_odd, out_even;
  logic [17:0] out_odd18, out_even18;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  pxs_pair_splitter i_pxs_pair_splitter (.*);

  // reference state
  logic        m_de_q = 0, m_second = 0, m_par = 0, m_arm = 0, m_err = 0;
  logic        m_hde = 0, m_hhs = 0, m_hvs = 0;
  logic [23:0] m_hpix = '0;
  logic        e_valid = 0, e_de = 0, e_hs = 0, e_vs = 0, e_oo = 0;
  logic [23:0] e_odd = '0, e_even = '0;
  logic        was_rise = 0;

  function automatic logic [17:0] narrow(input logic [23:0] p);
    return {p[23:18], p[15:10], p[7:2]};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s %s: got %h expected %h at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic model_step();
    logic rise, first;
    was_rise = 1'b0;
    if (rst) begin
      {m_de_q, m_second, m_par, m_arm, m_err, m_hde, m_hhs, m_hvs} = '0;
      m_hpix = '0;
      {e_valid, e_de, e_hs, e_vs, e_oo} = '0;
      e_odd = '0; e_even = '0;
      return;
    end
    rise  = in_de && !m_de_q;
    first = rise || !m_second;
    was_rise = rise;
    // R8: blanking parity counted from the falling edge
    if (rise) begin
      if (m_arm && m_par) m_err = 1'b1;
      m_par = 1'b0;
    end else if (!in_de) m_par = ~m_par;
    if (!in_de && m_de_q) m_arm = 1'b1;
    if (first) begin
      m_hpix = in_de ? in_pix : '0;
      m_hde = in_de; m_hhs = in_hs; m_hvs = in_vs;
      e_valid = 1'b0;
    end else begin
      e_valid = 1'b1;
      e_de = m_hde; e_hs = m_hhs; e_vs = m_hvs;
      e_odd  = m_hde ? m_hpix : '0;
      e_even = (m_hde && in_de) ? in_pix : '0;
      e_oo   = m_hde && !in_de;
    end
    m_second = first;
    m_de_q = in_de;
  endtask

  task automatic compare();
    string t;
    chk(was_rise ? "R4" : "R3", "out_valid", 32'(out_valid), 32'(e_valid));
    chk("R8", "blank_err", 32'(blank_err), 32'(m_err));
    if (e_valid) begin
      chk("R2", "out_odd", 32'(out_odd), 32'(e_odd));
      chk("R2", "out_even", 32'(out_even), 32'(e_even));
      chk(e_de ? "R2" : "R7", "out_de", 32'(out_de), 32'(e_de));
      chk("R6", "out_hs", 32'(out_hs), 32'(e_hs));
      chk("R6", "out_vs", 32'(out_vs), 32'(e_vs));
      chk("R5", "out_odd_only", 32'(out_odd_only), 32'(e_oo));
      chk("R9", "out_odd18", 32'(out_odd18), 32'(narrow(e_odd)));
      chk("R9", "out_even18", 32'(out_even18), 32'(narrow(e_even)));
    end else begin
      t = "R10";
      chk(t, "held pair", {out_odd[23:0], out_de, out_hs, out_vs, out_odd_only, 4'b0},
          {e_odd, e_de, e_hs, e_vs, e_oo, 4'b0});
      chk(t, "held even", 32'(out_even), 32'(e_even));
    end
  endtask

  task automatic cycle(input logic de, input logic hs, input logic vs, input logic [23:0] pix);
    @(negedge clk);
    in_de = de; in_hs = hs; in_vs = vs; in_pix = de ? pix : 24'($urandom);
    model_step();
    @(posedge clk);
    #1;
    compare();
  endtask

  task automatic line(input int act, input int blank);
    for (int i = 0; i < act; i++) cycle(1'b1, 1'b0, 1'b0, 24'($urandom));
    for (int i = 0; i < blank; i++) cycle(1'b0, i < 2, blank > 6 && i == 3, 24'h0);
  endtask

  task automatic do_reset(input int n);
    rst = 1'b1;
    for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, 1'b0, 24'h0);
    rst = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    do_reset(3);
    // R1: reset state visible at the ports
    chk("R1", "out_valid", 32'(out_valid), 0);
    chk("R1", "blank_err", 32'(blank_err), 0);
    chk("R1", "out_odd", 32'(out_odd), 0);
    chk("R1", "out_even", 32'(out_even), 0);
    chk("R1", "out_de/odd_only", {out_de, out_odd_only}, 0);
    cycle(1'b0, 1'b0, 1'b0, 24'h0);
    chk("R1", "out_valid after release", 32'(out_valid), 0);
    cycle(1'b0, 1'b0, 1'b0, 24'h0);

    // R2/R9 directed: distinct color bit patterns
    cycle(1'b1, 1'b1, 1'b0, 24'hFC_03_A5);
    cycle(1'b1, 1'b0, 1'b1, 24'h01_80_FF);
    line(6, 6);
    line(8, 4);
    // R5: odd active length leaves a lone pixel
    line(5, 6);
    line(1, 4);
    // R4/R8: odd blanking restarts phase and sets sticky flag
    line(4, 5);
    line(6, 4);
    chk("R8", "blank_err sticky", 32'(blank_err), 1);
    line(3, 3);
    do_reset(2);
    chk("R8", "blank_err cleared by reset", 32'(blank_err), 0);
    cycle(1'b0, 1'b0, 1'b0, 24'h0);
    cycle(1'b0, 1'b0, 1'b0, 24'h0);

    // random lines with even blanking
    for (int k = 0; k < 300; k++) begin
      int a, b;
      a = 1 + int'($urandom_range(0, 19));
      b = 2 * (1 + int'($urandom_range(0, 5)));
      line(a, b);
    end
    chk("R8", "no error on even blanking", 32'(blank_err), 0);
    // random lines including odd blanking
    for (int k = 0; k < 100; k++) begin
      line(1 + int'($urandom_range(0, 9)), 1 + int'($urandom_range(0, 9)));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(1_500_000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule